// File: doc/BRIEF.md
# CPU Error Register with Kernel Stack Guard

This block collects the causes of CPU faults in a sticky, memory-mapped error register. It also checks every kernel-mode stack push against two fixed limits. A push into the upper guard zone completes and then raises a warning trap. A push at or below the lower limit is aborted. When any bus or MMU fault hits a stack push, the fault becomes a fatal stack error. The block then sets the red-stack bit next to the cause bit, loads the stack pointer with an emergency value, and requests a trap.

The CPU core reports push events with the target stack address, together with the current mode, a HALT-executed strobe and four abort strobes: odd address, non-existent memory, I/O bus timeout and MMU abort. The block answers with a short response sequence from a small state machine:

- `ST_IDLE` accepts events.
- `ST_TRAP` asserts `trap_req` with the vector.
- `ST_ABORT` asserts `abort_req` and then moves to `ST_TRAP`.
- `ST_FATAL` asserts `abort_req` and `fatal_stack` and then moves to `ST_FORCE`.
- `ST_FORCE` asserts `sp_load` with the emergency pointer and then moves to `ST_TRAP`.
- `ST_TRAP` always returns to `ST_IDLE`.

From `ST_IDLE` a trap-class event goes to `ST_TRAP`, an abort-class event to `ST_ABORT` and a fatal event to `ST_FATAL`. Software reads `err_reg`. Any write strobe clears it.

Top module: `cpu_error_unit`

## Requirements
- R1: During and after reset, `err_reg` is 0, and `trap_req`, `abort_req`, `fatal_stack` and `sp_load` are low, until an event arrives.
- R2: A push with no fault, in kernel mode (`cpu_mode`=00), with `push_sp` above 0o340 and at most 0o400, sets bit 3 (0o10). In the next cycle `trap_req` is high and `abort_req` is low.
- R3: A push with no fault, in kernel mode, with `push_sp` at most 0o340, sets bit 2 (0o4). The next cycle has `abort_req`, and the cycle after that has `trap_req`.
- R4: A push without a fault outside kernel mode, or a kernel push with `push_sp` above 0o400, changes no register bit and starts no response.
- R5: A fault outside a push sets only its cause bit: odd address sets bit 6 (0o100), non-existent memory sets bit 5 (0o40), I/O timeout sets bit 4 (0o20), and an MMU abort sets no bit. Then comes one cycle of `abort_req`, then one of `trap_req`.
- R6: A fault together with `push_valid`, in any mode, sets bit 2 plus the cause bit (odd gives 0o104, timeout 0o024, non-existent memory 0o044, MMU 0o004). The next cycle has `abort_req` and `fatal_stack`, then a cycle of `sp_load` with `sp_load_val`=4, then a cycle of `trap_req`.
- R7: `halt_exec` in user mode (`cpu_mode`=11) sets bit 7 (0o200) and gives `trap_req` in the next cycle. `halt_exec` in any other mode has no effect.
- R8: Priority goes fault first, then stack limit, then illegal halt. Only the highest-priority event present is recorded and answered.
- R9: `reg_wr` clears every bit of `err_reg` at the next edge. A bit set by an event accepted on that same edge stays set.
- R10: Bits stay set until cleared and collect by OR. Bits 0, 1 and 8 and above always read 0.
- R11: An event that arrives while a response sequence is in progress is ignored. It sets no bit and starts no sequence.
- R12: `trap_vec` is 4 exactly when `trap_req` is high, and 0 otherwise. `sp_load_val` is 4 exactly when `sp_load` is high, and 0 otherwise. At most one of `trap_req`, `abort_req` and `sp_load` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | A stack push is being made this cycle |
| push_sp | input | 16 | Target address of the push |
| cpu_mode | input | 2 | Current mode: 00 kernel, 11 user |
| halt_exec | input | 1 | HALT instruction executed |
| flt_odd | input | 1 | Odd-address abort |
| flt_nxm | input | 1 | Non-existent memory abort |
| flt_iobto | input | 1 | I/O bus timeout abort |
| flt_mmu | input | 1 | MMU abort |
| reg_wr | input | 1 | Write strobe to the error register (clears it) |
| err_reg | output | 16 | Error register read value |
| trap_req | output | 1 | Trap request |
| trap_vec | output | 8 | Trap vector, valid with `trap_req` |
| abort_req | output | 1 | Abort the current access |
| fatal_stack | output | 1 | Fatal stack error in progress |
| sp_load | output | 1 | Load the stack pointer with `sp_load_val` |
| sp_load_val | output | 16 | Emergency stack pointer value |

## Verification
The assertions assume that the core drives each event strobe for one cycle only and that the reset pulse lasts several clocks. They make no assumption about when events arrive relative to a response sequence, because the block must drop those events itself. The stimulus therefore applies single-cycle pulses and deliberately places some of them inside running sequences and on the same edge as a register write. A behavioural model with a queue of pending response cycles predicts every output on every clock.

// File: rtl/cpuerr_pkg.sv
package cpuerr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ABORT,
        ST_FATAL,
        ST_FORCE,
        ST_TRAP
    } resp_state_t;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_TRAP,
        EV_ABORT,
        EV_FATAL
    } evt_kind_t;

    localparam int BIT_RSV   = 2;
    localparam int BIT_YSV   = 3;
    localparam int BIT_IOBTO = 4;
    localparam int BIT_NXM   = 5;
    localparam int BIT_ADDR  = 6;
    localparam int BIT_HALT  = 7;

    localparam logic [1:0] MODE_KERNEL = 2'b00;
    localparam logic [1:0] MODE_USER   = 2'b11;

endpackage

// File: rtl/cpuerr_classify.sv
module cpuerr_classify
    import cpuerr_pkg::*;
#(
    parameter int             AW           = 16,
    parameter int             DW           = 16,
    parameter logic [AW-1:0]  YELLOW_LIMIT = AW'('o400),
    parameter logic [AW-1:0]  RED_LIMIT    = AW'('o340)
) (
    input  logic          push_valid,
    input  logic [AW-1:0] push_sp,
    input  logic [1:0]    cpu_mode,
    input  logic          halt_exec,
    input  logic          flt_odd,
    input  logic          flt_nxm,
    input  logic          flt_iobto,
    input  logic          flt_mmu,
    output evt_kind_t     kind,
    output logic [DW-1:0] set_mask
);

    logic          any_fault;
    logic          kern_push;
    logic [DW-1:0] cause;

    always_comb begin
        any_fault = flt_odd | flt_nxm | flt_iobto | flt_mmu;
        kern_push = push_valid && (cpu_mode == MODE_KERNEL);

        cause             = '0;
        cause[BIT_ADDR]   = flt_odd;
        cause[BIT_NXM]    = flt_nxm;
        cause[BIT_IOBTO]  = flt_iobto;

        kind     = EV_NONE;
        set_mask = '0;
        if (any_fault) begin
            set_mask = cause;
            if (push_valid) begin
                kind              = EV_FATAL;
                set_mask[BIT_RSV] = 1'b1;
            end else begin
                kind = EV_ABORT;
            end
        end else if (kern_push && (push_sp <= RED_LIMIT)) begin
            kind              = EV_ABORT;
            set_mask[BIT_RSV] = 1'b1;
        end else if (kern_push && (push_sp <= YELLOW_LIMIT)) begin
            kind              = EV_TRAP;
            set_mask[BIT_YSV] = 1'b1;
        end else if (halt_exec && (cpu_mode == MODE_USER)) begin
            kind               = EV_TRAP;
            set_mask[BIT_HALT] = 1'b1;
        end
    end

endmodule

// File: rtl/cpuerr_fsm.sv
module cpuerr_fsm
    import cpuerr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  evt_kind_t kind,
    output logic      idle,
    output logic      trap_req,
    output logic      abort_req,
    output logic      fatal_stack,
    output logic      sp_load
);

    resp_state_t state_q;
    resp_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                unique case (kind)
                    EV_TRAP:  state_d = ST_TRAP;
                    EV_ABORT: state_d = ST_ABORT;
                    EV_FATAL: state_d = ST_FATAL;
                    default:  state_d = ST_IDLE;
                endcase
            end
            ST_ABORT: state_d = ST_TRAP;
            ST_FATAL: state_d = ST_FORCE;
            ST_FORCE: state_d = ST_TRAP;
            ST_TRAP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        idle        = 1'b0;
        trap_req    = 1'b0;
        abort_req   = 1'b0;
        fatal_stack = 1'b0;
        sp_load     = 1'b0;
        unique case (state_q)
            ST_IDLE:  idle = 1'b1;
            ST_ABORT: abort_req = 1'b1;
            ST_FATAL: begin
                abort_req   = 1'b1;
                fatal_stack = 1'b1;
            end
            ST_FORCE: sp_load = 1'b1;
            ST_TRAP:  trap_req = 1'b1;
            default:  idle = 1'b0;
        endcase
    end

endmodule

// File: rtl/cpuerr_reg.sv
module cpuerr_reg #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          set_en,
    input  logic [DW-1:0] set_mask,
    output logic [DW-1:0] err_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= '0;
        end else begin
            err_q <= (clr ? '0 : err_q) | (set_en ? set_mask : '0);
        end
    end

endmodule

// File: rtl/cpu_error_unit.sv
module cpu_error_unit
    import cpuerr_pkg::*;
#(
    parameter int            AW           = 16,
    parameter int            DW           = 16,
    parameter int            VW           = 8,
    parameter logic [AW-1:0] YELLOW_LIMIT = AW'('o400),
    parameter logic [AW-1:0] RED_LIMIT    = AW'('o340),
    parameter logic [VW-1:0] VECTOR       = VW'(4),
    parameter logic [AW-1:0] EMERG_SP     = AW'(4)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic [AW-1:0] push_sp,
    input  logic [1:0]    cpu_mode,
    input  logic          halt_exec,
    input  logic          flt_odd,
    input  logic          flt_nxm,
    input  logic          flt_iobto,
    input  logic          flt_mmu,
    input  logic          reg_wr,
    output logic [DW-1:0] err_reg,
    output logic          trap_req,
    output logic [VW-1:0] trap_vec,
    output logic          abort_req,
    output logic          fatal_stack,
    output logic          sp_load,
    output logic [AW-1:0] sp_load_val
);

    evt_kind_t     kind;
    logic [DW-1:0] set_mask;
    logic          idle;

    cpuerr_classify #(
        .AW(AW), .DW(DW), .YELLOW_LIMIT(YELLOW_LIMIT), .RED_LIMIT(RED_LIMIT)
    ) u_class (
        .push_valid (push_valid),
        .push_sp    (push_sp),
        .cpu_mode   (cpu_mode),
        .halt_exec  (halt_exec),
        .flt_odd    (flt_odd),
        .flt_nxm    (flt_nxm),
        .flt_iobto  (flt_iobto),
        .flt_mmu    (flt_mmu),
        .kind       (kind),
        .set_mask   (set_mask)
    );

    cpuerr_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .kind        (kind),
        .idle        (idle),
        .trap_req    (trap_req),
        .abort_req   (abort_req),
        .fatal_stack (fatal_stack),
        .sp_load     (sp_load)
    );

    cpuerr_reg #(.DW(DW)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (reg_wr),
        .set_en   (idle),
        .set_mask (set_mask),
        .err_q    (err_reg)
    );

    assign trap_vec    = trap_req ? VECTOR : '0;
    assign sp_load_val = sp_load ? EMERG_SP : '0;

endmodule

// File: rtl/cpu_error_unit_chk.sv
module cpu_error_unit_chk #(
    parameter int            AW       = 16,
    parameter int            DW       = 16,
    parameter int            VW       = 8,
    parameter logic [VW-1:0] VECTOR   = VW'(4),
    parameter logic [AW-1:0] EMERG_SP = AW'(4)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [DW-1:0] err_reg,
    input logic          trap_req,
    input logic [VW-1:0] trap_vec,
    input logic          abort_req,
    input logic          fatal_stack,
    input logic          sp_load,
    input logic [AW-1:0] sp_load_val
);

    AST_ABORT_THEN_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_req && !fatal_stack) |=> trap_req); // R5

    AST_FATAL_THEN_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_stack |=> (sp_load && sp_load_val == EMERG_SP)); // R6

    AST_FORCE_THEN_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        sp_load |=> trap_req); // R6

    AST_FATAL_HAS_RSV: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_stack |-> err_reg[2]); // R6

    AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ((err_reg & $past(err_reg)) == $past(err_reg))); // R10

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (err_reg[1:0] == 2'b00) && (err_reg[DW-1:8] == '0)); // R10

    AST_VEC_WITH_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (trap_vec == VECTOR)); // R12

    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trap_req, abort_req, sp_load})); // R12

endmodule

bind cpu_error_unit cpu_error_unit_chk #(
    .AW(AW), .DW(DW), .VW(VW), .VECTOR(VECTOR), .EMERG_SP(EMERG_SP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .err_reg     (err_reg),
    .trap_req    (trap_req),
    .trap_vec    (trap_vec),
    .abort_req   (abort_req),
    .fatal_stack (fatal_stack),
    .sp_load     (sp_load),
    .sp_load_val (sp_load_val)
);

// File: tb/tb_cpu_error_unit.sv
module tb_cpu_error_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic [15:0] push_sp = '0;
    logic [1:0]  cpu_mode = 2'b00;
    logic        halt_exec = 1'b0;
    logic        flt_odd = 1'b0;
    logic        flt_nxm = 1'b0;
    logic        flt_iobto = 1'b0;
    logic        flt_mmu = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] err_reg;
    logic        trap_req;
    logic [7:0]  trap_vec;
    logic        abort_req;
    logic        fatal_stack;
    logic        sp_load;
    logic [15:0] sp_load_val;

    cpu_error_unit dut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_sp(push_sp),
        .cpu_mode(cpu_mode), .halt_exec(halt_exec), .flt_odd(flt_odd),
        .flt_nxm(flt_nxm), .flt_iobto(flt_iobto), .flt_mmu(flt_mmu),
        .reg_wr(reg_wr), .err_reg(err_reg), .trap_req(trap_req),
        .trap_vec(trap_vec), .abort_req(abort_req), .fatal_stack(fatal_stack),
        .sp_load(sp_load), .sp_load_val(sp_load_val)
    );

    always #4 clk = ~clk;

    // Reference model: 0 none, 1 trap, 2 abort, 3 fatal abort, 4 force SP
    int          n_checks = 0;
    int          n_fail = 0;
    int          cycles = 0;
    int          cur = 0;
    int          pend[$];
    logic [15:0] exp_reg = '0;
    string       tag = "R1";

    always @(posedge clk) begin
        int          ev;
        logic [15:0] m;
        bit          flt;
        if (!rst_n) begin
            exp_reg = '0;
            cur = 0;
            pend.delete();
        end else begin
            ev = 0;
            m = '0;
            flt = flt_odd || flt_nxm || flt_iobto || flt_mmu;
            if (flt) begin
                if (flt_odd)   m = m | 16'o100;
                if (flt_nxm)   m = m | 16'o040;
                if (flt_iobto) m = m | 16'o020;
                if (push_valid) begin
                    m = m | 16'o004;
                    ev = 3;
                end else begin
                    ev = 2;
                end
            end else if (push_valid && cpu_mode == 2'b00 && push_sp <= 16'o340) begin
                m = 16'o004;
                ev = 2;
            end else if (push_valid && cpu_mode == 2'b00 && push_sp <= 16'o400) begin
                m = 16'o010;
                ev = 1;
            end else if (halt_exec && cpu_mode == 2'b11) begin
                m = 16'o200;
                ev = 1;
            end
            if (reg_wr) exp_reg = '0;
            if (cur == 0) begin
                exp_reg = exp_reg | m;
                if (ev == 1) pend = '{1};
                if (ev == 2) pend = '{2, 1};
                if (ev == 3) pend = '{3, 4, 1};
            end
            if (pend.size() > 0) cur = pend.pop_front();
            else cur = 0;
        end
    end

    // Compare every cycle on the falling edge (R12 covered by vec/sp checks)
    always @(negedge clk) begin
        logic       e_trap, e_abort, e_fatal, e_load;
        logic [7:0] e_vec;
        logic [15:0] e_spv;
        e_trap  = (cur == 1);
        e_abort = (cur == 2) || (cur == 3);
        e_fatal = (cur == 3);
        e_load  = (cur == 4);
        e_vec   = e_trap ? 8'd4 : 8'd0;
        e_spv   = e_load ? 16'd4 : 16'd0;
        n_checks++;
        if (err_reg !== exp_reg || trap_req !== e_trap || abort_req !== e_abort ||
            fatal_stack !== e_fatal || sp_load !== e_load || trap_vec !== e_vec ||
            sp_load_val !== e_spv) begin
            n_fail++;
            $display("FAIL %s: err=%o/%o trap=%b/%b vec=%0d/%0d abort=%b/%b fatal=%b/%b load=%b/%b spv=%0d/%0d (actual/expected)",
                     tag, err_reg, exp_reg, trap_req, e_trap, trap_vec, e_vec,
                     abort_req, e_abort, fatal_stack, e_fatal, sp_load, e_load,
                     sp_load_val, e_spv);
        end
    end

    task automatic pulse(input logic pv, input logic [15:0] sp, input logic [1:0] md,
                         input logic h, input logic o, input logic n, input logic t,
                         input logic mm, input logic w);
        @(negedge clk);
        push_valid = pv; push_sp = sp; cpu_mode = md; halt_exec = h;
        flt_odd = o; flt_nxm = n; flt_iobto = t; flt_mmu = mm; reg_wr = w;
        @(negedge clk);
        push_valid = 0; push_sp = '0; cpu_mode = 2'b00; halt_exec = 0;
        flt_odd = 0; flt_nxm = 0; flt_iobto = 0; flt_mmu = 0; reg_wr = 0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_reg();
        pulse(0, 0, 2'b00, 0, 0, 0, 0, 0, 1);
        settle(2);
    endtask

    initial begin
        tag = "R1";
        settle(3);
        rst_n = 1'b1;
        settle(3);

        tag = "R2"; // yellow zone at 0o400 and 0o341
        pulse(1, 16'o400, 2'b00, 0, 0, 0, 0, 0, 0); settle(4);
        pulse(1, 16'o341, 2'b00, 0, 0, 0, 0, 0, 0); settle(4);
        clear_reg();

        tag = "R3"; // red zone at 0o340 and 0
        pulse(1, 16'o340, 2'b00, 0, 0, 0, 0, 0, 0); settle(4);
        pulse(1, 16'o000, 2'b00, 0, 0, 0, 0, 0, 0); settle(4);
        clear_reg();

        tag = "R4"; // no check outside kernel, nothing above 0o400
        pulse(1, 16'o100, 2'b11, 0, 0, 0, 0, 0, 0); settle(4);
        pulse(1, 16'o200, 2'b01, 0, 0, 0, 0, 0, 0); settle(4);
        pulse(1, 16'o401, 2'b00, 0, 0, 0, 0, 0, 0); settle(4);

        tag = "R5"; // plain faults; R10 accumulation
        pulse(0, 0, 2'b00, 0, 1, 0, 0, 0, 0); settle(4);
        tag = "R10";
        pulse(0, 0, 2'b11, 0, 0, 1, 0, 0, 0); settle(4);
        pulse(0, 0, 2'b00, 0, 0, 0, 1, 0, 0); settle(4);
        tag = "R5";
        clear_reg();
        pulse(0, 0, 2'b00, 0, 0, 0, 0, 1, 0); settle(4);

        tag = "R6"; // fatal stack errors
        pulse(1, 16'o1001, 2'b00, 0, 1, 0, 0, 0, 0); settle(5); clear_reg();
        pulse(1, 16'o160004, 2'b00, 0, 0, 0, 1, 0, 0); settle(5); clear_reg();
        pulse(1, 16'o140004, 2'b00, 0, 0, 1, 0, 0, 0); settle(5); clear_reg();
        pulse(1, 16'o20004, 2'b11, 0, 0, 0, 0, 1, 0); settle(5); clear_reg();

        tag = "R7"; // illegal halt in user mode only
        pulse(0, 0, 2'b11, 1, 0, 0, 0, 0, 0); settle(4);
        pulse(0, 0, 2'b00, 1, 0, 0, 0, 0, 0); settle(4);
        pulse(0, 0, 2'b01, 1, 0, 0, 0, 0, 0); settle(4);
        clear_reg();

        tag = "R8"; // priorities
        pulse(0, 0, 2'b11, 1, 1, 0, 0, 0, 0); settle(4); clear_reg();
        pulse(1, 16'o300, 2'b11, 1, 0, 0, 0, 0, 0); settle(4); clear_reg();
        pulse(1, 16'o340, 2'b00, 0, 1, 0, 0, 0, 0); settle(5); clear_reg();

        tag = "R9"; // clear with new event on the same edge
        pulse(0, 0, 2'b00, 0, 1, 0, 0, 0, 0); settle(4);
        pulse(1, 16'o400, 2'b00, 0, 0, 0, 0, 0, 1); settle(4);
        clear_reg();

        tag = "R11"; // events during a running sequence are dropped
        pulse(1, 16'o1001, 2'b00, 0, 1, 0, 0, 0, 0);
        pulse(0, 0, 2'b00, 0, 0, 1, 0, 0, 0);
        settle(4);
        pulse(0, 0, 2'b00, 0, 0, 0, 1, 0, 0);
        pulse(0, 0, 2'b11, 1, 0, 0, 0, 0, 0);
        settle(4);

        tag = "R12";
        settle(3);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule